// File: doc/BRIEF.md
# ADC Result Slot Sequencer

This block keeps track of where the results of a multi-channel analog-to-digital converter land. It holds a bank of result slots (16 by default). Each completed conversion is written into the slot that a wrapping slot counter selects. The slot's conversion-complete flag is then raised and the counter steps forward. Software reads results through an address/read-enable port and acknowledges them, either by reading the slot or by writing ones to a flag-clear mask. If a fresh result lands on a slot whose flag is still raised, a sticky overrun bit is set.

A sequence is opened by a start pulse. The pulse is tagged as coming from a control-register write or from an external trigger. The sequence closes after a programmed number of results. In single-shot (non-FIFO) mode the slot counter goes back to zero at every start and after the final result, so each sequence fills slots from index 0. In FIFO mode the counter carries over from one sequence to the next, so results form a circular buffer across sequences. Two events always return the counter to zero, in either mode: an abort, and a start that comes from a control write. The converter itself, channel selection and conversion timing sit outside this block.

Top module: `adc_result_seq`

## Requirements
- R1: After reset the slot counter is 0, all conversion-complete flags are 0, overrun is 0, every slot reads 0 and no sequence is open, so a done strobe has no effect.
- R2: A done strobe accepted while a sequence is open writes the data into the slot indexed by the counter and sets that slot's flag. The counter then advances by one, modulo the slot count. Flags never rise without a done strobe, and at most one rises per cycle.
- R3: The sequence length is `seq_len_m1`+1, captured at the start pulse. Once that many results are stored the sequence closes, and later done strobes change no slot, flag or counter until the next start.
- R4: In non-FIFO mode (`fifo_mode`=0) the counter is 0 after every start and after the final result of a sequence.
- R5: In FIFO mode a trigger start (`start_src`=0) leaves the counter unchanged. The final result of a sequence advances it like any other result, and the counter wraps from 15 to 0.
- R6: A control-write start (`start_src`=1) or an abort sets the counter to 0 in either mode. An abort closes the sequence, leaves flags, overrun and slot contents untouched, and overrides a start pulse in the same cycle; the start is then dropped.
- R7: Overrun sets when an accepted result is written into a slot whose flag is set at that moment.
- R8: Overrun is cleared by an `ovr_clr` pulse or by a start that is not overridden by an abort. A new overrun in the same cycle as `ovr_clr` leaves it set.
- R9: A flag clears when its bit is 1 in `ccf_clr_mask`, or when `rd_en` is high with `rd_addr` selecting its slot. A result stored to that slot in the same cycle leaves the flag set.
- R10: A done strobe in the same cycle as a start or an abort is dropped: no slot, flag or overrun changes, and it does not count toward the sequence.
- R11: `rd_data` shows, combinationally, the contents of the slot selected by `rd_addr`, whether or not `rd_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_done | input | 1 | One-cycle strobe: a conversion result is valid |
| conv_data | input | DATA_W | Conversion result |
| seq_start | input | 1 | One-cycle pulse opening a new sequence |
| start_src | input | 1 | Source of the start: 1 control write, 0 external trigger |
| abort | input | 1 | One-cycle pulse aborting the current sequence |
| fifo_mode | input | 1 | 1 selects FIFO (carry-over) counter behaviour |
| seq_len_m1 | input | CNT_W | Sequence length minus one |
| rd_en | input | 1 | Result read access; clears the addressed flag |
| rd_addr | input | CNT_W | Slot index for reads |
| ccf_clr_mask | input | 2**CNT_W | Write-one-to-clear mask for the flags |
| ovr_clr | input | 1 | Write-one-to-clear for overrun |
| conv_cnt | output | CNT_W | Slot counter: the slot for the next result |
| ccf | output | 2**CNT_W | Conversion-complete flags, one per slot |
| overrun | output | 1 | Sticky overrun status |
| rd_data | output | DATA_W | Contents of the slot at `rd_addr` |

## Verification
The bench builds the block with its defaults: CNT_W=4, giving 16 slots, and DATA_W=10. A 12-result FIFO sequence that starts at slot 6 therefore crosses the 15-to-0 wrap. The same sequence writes onto slots that were never acknowledged, so one run covers both the wrap and the overrun. A length of 16 can be programmed, so the longest possible sequence is also reachable. The directed steps aim at the same-cycle collisions: set against clear on a flag and on overrun, abort against start, and a done strobe against start or abort. A randomised stretch then mixes every input.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic {
    SRC_TRIG = 1'b0,
    SRC_CTRL = 1'b1
  } start_src_e;

endpackage

// File: rtl/adc_seq_rst_sync.sv
module adc_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic             seq_start,
  input  logic             start_src,
  input  logic             abort,
  input  logic             fifo_mode,
  input  logic [CNT_W-1:0] len_m1,
  output logic [CNT_W-1:0] cnt,
  output logic             accept,
  output logic             start_eff
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] done_q, done_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             act_q, act_d;
  logic             upd_en;
  logic             last_res;

  always_comb begin
    start_eff = seq_start & ~abort;
    accept    = conv_done & act_q & ~abort & ~seq_start;
    last_res  = (done_q == len_q);
    cnt_d     = cnt_q;
    done_d    = done_q;
    len_d     = len_q;
    act_d     = act_q;
    upd_en    = 1'b0;
    if (abort) begin
      upd_en = 1'b1;
      cnt_d  = '0;
      act_d  = 1'b0;
    end else if (seq_start) begin
      upd_en = 1'b1;
      act_d  = 1'b1;
      done_d = '0;
      len_d  = len_m1;
      if ((start_src_e'(start_src) == SRC_CTRL) || !fifo_mode) begin
        cnt_d = '0;
      end
    end else if (accept) begin
      upd_en = 1'b1;
      if (last_res) begin
        act_d = 1'b0;
        cnt_d = fifo_mode ? cnt_q + 1'b1 : '0;
      end else begin
        done_d = done_q + 1'b1;
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= '0;
      len_q  <= '0;
      act_q  <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      len_q  <= len_d;
      act_q  <= act_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/adc_seq_flags.sv
module adc_seq_flags #(
  parameter int CNT_W = 4,
  localparam int NUM_SLOTS = 1 << CNT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [CNT_W-1:0]     wr_idx,
  input  logic                 start_eff,
  input  logic                 ovr_clr,
  input  logic [NUM_SLOTS-1:0] clr_mask,
  input  logic                 rd_en,
  input  logic [CNT_W-1:0]     rd_idx,
  output logic [NUM_SLOTS-1:0] ccf,
  output logic                 overrun
);

  logic [NUM_SLOTS-1:0] ccf_q;
  logic                 ovr_q, ovr_d, ovr_en;
  logic                 hit;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_flag
    logic set_i, clr_i, d_i, en_i;

    always_comb begin
      set_i = accept && (wr_idx == CNT_W'(i));
      clr_i = clr_mask[i] || (rd_en && (rd_idx == CNT_W'(i)));
      en_i  = set_i || clr_i;
      d_i   = set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ccf_q[i] <= 1'b0;
      end else if (en_i) begin
        ccf_q[i] <= d_i;
      end
    end
  end

  always_comb begin
    hit    = accept && ccf_q[wr_idx];
    ovr_d  = ovr_q;
    ovr_en = 1'b0;
    if (start_eff) begin
      ovr_d  = 1'b0;
      ovr_en = 1'b1;
    end else if (hit) begin
      ovr_d  = 1'b1;
      ovr_en = 1'b1;
    end else if (ovr_clr) begin
      ovr_d  = 1'b0;
      ovr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (ovr_en) begin
      ovr_q <= ovr_d;
    end
  end

  assign ccf     = ccf_q;
  assign overrun = ovr_q;

endmodule

// File: rtl/adc_seq_store.sv
module adc_seq_store #(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 10,
  localparam int NUM_SLOTS = 1 << CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CNT_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slot_q [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic wr_en_i;

    always_comb begin
      wr_en_i = accept && (wr_idx == CNT_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[i] <= '0;
      end else if (wr_en_i) begin
        slot_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/adc_result_seq.sv
module adc_result_seq #(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 10,
  localparam int NUM_SLOTS = 1 << CNT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 conv_done,
  input  logic [DATA_W-1:0]    conv_data,
  input  logic                 seq_start,
  input  logic                 start_src,
  input  logic                 abort,
  input  logic                 fifo_mode,
  input  logic [CNT_W-1:0]     seq_len_m1,
  input  logic                 rd_en,
  input  logic [CNT_W-1:0]     rd_addr,
  input  logic [NUM_SLOTS-1:0] ccf_clr_mask,
  input  logic                 ovr_clr,
  output logic [CNT_W-1:0]     conv_cnt,
  output logic [NUM_SLOTS-1:0] ccf,
  output logic                 overrun,
  output logic [DATA_W-1:0]    rd_data
);

  logic             rst_q_n;
  logic             accept;
  logic             start_eff;
  logic [CNT_W-1:0] slot_idx;

  adc_seq_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  adc_seq_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .conv_done (conv_done),
    .seq_start (seq_start),
    .start_src (start_src),
    .abort     (abort),
    .fifo_mode (fifo_mode),
    .len_m1    (seq_len_m1),
    .cnt       (slot_idx),
    .accept    (accept),
    .start_eff (start_eff)
  );

  adc_seq_flags #(.CNT_W(CNT_W)) i_flags (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .accept    (accept),
    .wr_idx    (slot_idx),
    .start_eff (start_eff),
    .ovr_clr   (ovr_clr),
    .clr_mask  (ccf_clr_mask),
    .rd_en     (rd_en),
    .rd_idx    (rd_addr),
    .ccf       (ccf),
    .overrun   (overrun)
  );

  adc_seq_store #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_store (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .accept  (accept),
    .wr_idx  (slot_idx),
    .wr_data (conv_data),
    .rd_idx  (rd_addr),
    .rd_data (rd_data)
  );

  assign conv_cnt = slot_idx;

endmodule

// File: rtl/adc_result_seq_chk.sv
module adc_result_seq_chk #(
  parameter int CNT_W = 4,
  localparam int NUM_SLOTS = 1 << CNT_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 conv_done,
  input logic                 seq_start,
  input logic                 start_src,
  input logic                 abort,
  input logic                 ovr_clr,
  input logic [CNT_W-1:0]     conv_cnt,
  input logic [NUM_SLOTS-1:0] ccf,
  input logic                 overrun
);

  AST_ABORT_ZEROS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (conv_cnt == '0)); // R6

  AST_CTRL_START_ZEROS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && start_src) |=> (conv_cnt == '0)); // R6

  AST_CNT_HOLDS_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !seq_start && !abort) |=> $stable(conv_cnt)); // R2

  AST_CCF_RISE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> ((ccf & ~$past(ccf)) == '0)); // R2

  AST_ONE_CCF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> ($countones(ccf & ~$past(ccf)) <= 1)); // R2

  AST_OVR_RISE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> !$rose(overrun)); // R7

  AST_START_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && !abort) |=> !overrun); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr && !(seq_start && !abort)) |=> overrun); // R8

endmodule

bind adc_result_seq adc_result_seq_chk #(.CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .conv_done (conv_done),
  .seq_start (seq_start),
  .start_src (start_src),
  .abort     (abort),
  .ovr_clr   (ovr_clr),
  .conv_cnt  (conv_cnt),
  .ccf       (ccf),
  .overrun   (overrun)
);

// File: tb/test_adc_result_seq.sv
module test_adc_result_seq;

  localparam int CNT_W  = 4;
  localparam int DATA_W = 10;
  localparam int NS     = 1 << CNT_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              conv_done;
  logic [DATA_W-1:0] conv_data;
  logic              seq_start;
  logic              start_src;
  logic              abort;
  logic              fifo_mode;
  logic [CNT_W-1:0]  seq_len_m1;
  logic              rd_en;
  logic [CNT_W-1:0]  rd_addr;
  logic [NS-1:0]     ccf_clr_mask;
  logic              ovr_clr;
  logic [CNT_W-1:0]  conv_cnt;
  logic [NS-1:0]     ccf;
  logic              overrun;
  logic [DATA_W-1:0] rd_data;

  always #10 clk = ~clk;

  adc_result_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_adc_result_seq (
    .clk, .rst_n, .conv_done, .conv_data, .seq_start, .start_src, .abort,
    .fifo_mode, .seq_len_m1, .rd_en, .rd_addr, .ccf_clr_mask, .ovr_clr,
    .conv_cnt, .ccf, .overrun, .rd_data
  );

  // Behavioural reference model
  int m_cnt, m_done, m_len;
  bit m_active, m_ovr;
  bit m_ccf [NS];
  int m_mem [NS];

  always @(posedge clk or negedge rst_n) begin
    bit st, acc, hit;
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_len = 0; m_active = 0; m_ovr = 0;
      for (int i = 0; i < NS; i++) begin m_ccf[i] = 0; m_mem[i] = 0; end
    end else begin
      st  = seq_start && !abort;
      acc = conv_done && m_active && !abort && !seq_start;
      hit = acc && m_ccf[m_cnt];
      for (int i = 0; i < NS; i++)
        if (ccf_clr_mask[i] || (rd_en && int'(rd_addr) == i)) m_ccf[i] = 0;
      if (acc) begin m_ccf[m_cnt] = 1; m_mem[m_cnt] = int'(conv_data); end
      if (st) m_ovr = 0;
      else if (hit) m_ovr = 1;
      else if (ovr_clr) m_ovr = 0;
      if (abort) begin
        m_cnt = 0; m_active = 0;
      end else if (seq_start) begin
        m_active = 1; m_done = 0; m_len = int'(seq_len_m1) + 1;
        if (start_src || !fifo_mode) m_cnt = 0;
      end else if (acc) begin
        m_done++;
        if (m_done == m_len) begin
          m_active = 0;
          m_cnt = fifo_mode ? (m_cnt + 1) % NS : 0;
        end else begin
          m_cnt = (m_cnt + 1) % NS;
        end
      end
    end
  end

  int total = 0;
  int bad   = 0;
  string cur_req = "R1";
  bit finished = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] model_ccf();
    logic [NS-1:0] v;
    for (int i = 0; i < NS; i++) v[i] = m_ccf[i];
    return v;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk(cur_req, "model cnt", 32'(conv_cnt), 32'(m_cnt));
    chk(cur_req, "model ccf", 32'(ccf), 32'(model_ccf()));
    chk(cur_req, "model ovr", 32'(overrun), 32'(m_ovr));
    chk(cur_req, "model rd_data", 32'(rd_data), 32'(m_mem[rd_addr]));
  endtask

  task automatic quiet();
    conv_done = 0; seq_start = 0; abort = 0; rd_en = 0;
    ccf_clr_mask = '0; ovr_clr = 0;
  endtask

  task automatic conv(int d);
    conv_done = 1; conv_data = DATA_W'(d);
    tick();
    conv_done = 0;
  endtask

  task automatic start(bit src, int len_m1);
    seq_start = 1; start_src = src; seq_len_m1 = CNT_W'(len_m1);
    tick();
    seq_start = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; quiet(); conv_data = '0; start_src = 0; fifo_mode = 0;
    seq_len_m1 = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) tick();
    // R1 reset state
    chk("R1", "cnt", 32'(conv_cnt), 0);
    chk("R1", "ccf", 32'(ccf), 0);
    chk("R1", "ovr", 32'(overrun), 0);
    conv(55);
    chk("R1", "ccf after idle done", 32'(ccf), 0);
    chk("R1", "rd_data slot0", 32'(rd_data), 0);

    // Phase A: non-FIFO, length 4
    cur_req = "R2";
    start(1, 3);
    conv(100); conv(101);
    chk("R2", "cnt after two", 32'(conv_cnt), 2);
    rd_addr = 1; tick();
    chk("R11", "rd_data slot1", 32'(rd_data), 101);
    conv(102); conv(103);
    chk("R4", "cnt after end", 32'(conv_cnt), 0);
    chk("R2", "ccf", 32'(ccf), 32'h000F);
    cur_req = "R3";
    conv(104);
    chk("R3", "ccf after closed", 32'(ccf), 32'h000F);
    rd_addr = 0; tick();
    chk("R3", "slot0 kept", 32'(rd_data), 100);
    cur_req = "R9";
    rd_en = 1; rd_addr = 1; tick(); rd_en = 0;
    chk("R9", "read clears", 32'(ccf), 32'h000D);
    ccf_clr_mask = 16'h0001; tick(); ccf_clr_mask = '0;
    chk("R9", "mask clears", 32'(ccf), 32'h000C);

    // Phase B: overrun in non-FIFO
    cur_req = "R7";
    start(0, 2);
    chk("R4", "cnt at trig start", 32'(conv_cnt), 0);
    conv(200); conv(201);
    chk("R7", "no ovr yet", 32'(overrun), 0);
    conv(202);
    chk("R7", "ovr on set slot", 32'(overrun), 1);
    chk("R4", "cnt after end", 32'(conv_cnt), 0);
    cur_req = "R8";
    ovr_clr = 1; tick(); ovr_clr = 0;
    chk("R8", "ovr_clr", 32'(overrun), 0);
    start(0, 0);
    ovr_clr = 1; conv(210); ovr_clr = 0;
    chk("R8", "set beats clear", 32'(overrun), 1);
    start(1, 0);
    chk("R8", "start clears ovr", 32'(overrun), 0);
    conv(211);

    // Phase C: FIFO carry-over and wrap
    cur_req = "R5";
    ccf_clr_mask = '1; ovr_clr = 1; tick(); quiet();
    fifo_mode = 1;
    start(1, 5);
    for (int i = 0; i < 6; i++) conv(300 + i);
    chk("R5", "cnt after fifo seq", 32'(conv_cnt), 6);
    chk("R2", "ccf", 32'(ccf), 32'h003F);
    start(0, 11);
    chk("R5", "trig start keeps cnt", 32'(conv_cnt), 6);
    for (int i = 0; i < 12; i++) conv(400 + i);
    chk("R5", "cnt wrapped", 32'(conv_cnt), 2);
    chk("R7", "ovr after wrap", 32'(overrun), 1);
    chk("R5", "ccf full", 32'(ccf), 32'hFFFF);

    // Phase D: abort
    cur_req = "R6";
    ccf_clr_mask = '1; tick(); quiet();
    start(0, 15);
    chk("R8", "start clears ovr", 32'(overrun), 0);
    conv(500); conv(501); conv(502);
    chk("R2", "cnt", 32'(conv_cnt), 5);
    abort = 1; conv(503); abort = 0;
    chk("R6", "abort zeros cnt", 32'(conv_cnt), 0);
    chk("R10", "done with abort dropped", 32'(ccf), 32'h001C);
    conv(504);
    chk("R3", "closed after abort", 32'(ccf), 32'h001C);
    abort = 1; start(0, 3); abort = 0;
    conv(505);
    chk("R6", "start under abort dropped", 32'(ccf), 32'h001C);
    chk("R6", "cnt", 32'(conv_cnt), 0);

    // Phase E: set beats clear on flags, done dropped on start
    cur_req = "R9";
    fifo_mode = 0;
    start(1, 1);
    rd_en = 1; rd_addr = 0; conv(600); rd_en = 0;
    chk("R9", "set beats read clear", 32'(ccf), 32'h001D);
    ccf_clr_mask = 16'h0002; conv(601); ccf_clr_mask = '0;
    chk("R9", "set beats mask clear", 32'(ccf), 32'h001F);
    rd_addr = 1; tick();
    chk("R11", "rd_data slot1", 32'(rd_data), 601);
    cur_req = "R10";
    conv_done = 1; conv_data = 10'd77; start(1, 3); conv_done = 0;
    rd_addr = 0; tick();
    chk("R10", "done with start dropped", 32'(rd_data), 600);
    chk("R10", "ccf unchanged", 32'(ccf), 32'h001F);
    chk("R10", "cnt", 32'(conv_cnt), 0);

    // Phase F: random mix, model compared every cycle
    cur_req = "R2";
    for (int n = 0; n < 4000; n++) begin
      conv_done    = ($urandom_range(0, 2) != 0);
      conv_data    = DATA_W'($urandom);
      seq_start    = ($urandom_range(0, 15) == 0);
      start_src    = $urandom_range(0, 1) == 1;
      abort        = ($urandom_range(0, 40) == 0);
      if (n % 500 == 0) fifo_mode = ~fifo_mode;
      seq_len_m1   = CNT_W'($urandom);
      rd_en        = ($urandom_range(0, 3) == 0);
      rd_addr      = CNT_W'($urandom);
      ccf_clr_mask = ($urandom_range(0, 5) == 0) ? NS'($urandom) : '0;
      ovr_clr      = ($urandom_range(0, 7) == 0);
      tick();
    end
    quiet();
    tick();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule